// File: doc/BRIEF.md
# Dual Shiftable-Window Disparity Correlator

This block scores candidate stereo matches for one scanline pixel at a time. The right-image stream is a complex I/Q sample from the orientation filters, and it goes into a history buffer deep enough for the largest allowed disparity. A left-image sample arrives in the same cycle. For that left sample, the block produces two sets of nine correlation scores. Each score is the real part of the left sample times the conjugate of a right sample taken some number of columns earlier. Each set covers nine consecutive disparities.

The two sets come from two windows that are placed independently on every pixel. The tracking window is centred on a disparity supplied with the pixel, normally that pixel's estimate from the previous frame, read from an external disparity store. The roving window is centred on a value that follows a fixed cycle and moves on by one step at each new-frame strobe. The roving window finds matches that lie outside the tracking window's reach, for example when a new object enters the scene or when tracking has locked onto a wrong match.

A larger disparity range costs only buffer depth and a wider read selector. The number of multipliers stays at nine per window whatever the range. Normalisation, summation over scales and peak detection are done downstream.

Top module: `dual_window_corr`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low and the roving centre is 10, so the first pixel's roving window starts at shift 6.
- R2: A pixel presented with `pix_valid` high at a clock edge has its results on the outputs, with `out_valid` high, after the next clock edge. `out_valid` is low in every other cycle.
- R3: Each score is the 33-bit signed value Lre·Rre + Lim·Rim. R is the right sample of the current line at column x−d, where x is the pixel's column and d is the shift.
- R4: Lane k of a window (bits k·33 to k·33+32 of its score bus, and bit k of its invalid mask) corresponds to shift lo+k. For an unclamped centre c, lo = c−4, and lo is reported on `trk_lo` or `rov_lo`.
- R5: A centre below 4 gives lo = 0.
- R6: A centre with c+4 > M gives lo = M−8. M, the effective maximum, is `max_disp` limited to the range 8 to MAXD.
- R7: A lane whose shift exceeds the pixel's column has its invalid bit set to 1 and its score set to 0. All other lanes have the invalid bit at 0.
- R8: A pixel presented with `line_start` high is column 0. Each later valid pixel is one column further on, saturating at the top of the column counter.
- R9: At each `frame_start` strobe, the roving centre steps as follows: from 0 to 10; from a value at or above M to 0; otherwise to the lesser of the value plus 9 and M. With M = 30 the cycle is 10, 19, 28, 30, 0, 10.
- R10: A `max_disp` above MAXD is treated as MAXD, both for window clamping and for the roving schedule.
- R11: The tracking centre is taken from `trk_center` for each pixel individually, in the same cycle as that pixel's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | New-frame strobe that advances the roving centre; given in a cycle without a pixel |
| pix_valid | input | 1 | Left and right samples are present this cycle |
| line_start | input | 1 | This pixel is column 0 of a new line |
| max_disp | input | DW | Programmable maximum disparity |
| trk_center | input | DW | Previous-frame disparity for this pixel |
| l_re | input | 16 | Left sample, real part (signed) |
| l_im | input | 16 | Left sample, imaginary part (signed) |
| r_re | input | 16 | Right sample, real part (signed) |
| r_im | input | 16 | Right sample, imaginary part (signed) |
| out_valid | output | 1 | Scores on the outputs belong to a pixel |
| trk_lo | output | DW | Lowest shift of the tracking window |
| rov_lo | output | DW | Lowest shift of the roving window |
| trk_inv | output | WIN | Tracking lanes with no right sample |
| rov_inv | output | WIN | Roving lanes with no right sample |
| trk_score | output | WIN·33 | Tracking window scores, lane 0 in the low bits |
| rov_score | output | WIN·33 | Roving window scores, lane 0 in the low bits |

## Verification
The bench builds the block with MAXD = 40, a nine-lane window and an 8-bit column counter, so DW is 6.

With these values, a `max_disp` of 63 is legal at the port and exceeds MAXD, which exercises the cap. A full roving cycle for M = 30 or M = 20 fits in a handful of short frames. Lines of a few dozen pixels still reach shifts where the right sample has not yet arrived, as well as both clamp edges.

Every output cycle is compared against a model built from the requirements, including the cycles where `out_valid` must stay low. The data includes the most negative sample values, which checks the full 33-bit score range.

// File: rtl/dwc_pkg.sv
// Shared sample and score types for the dual-window correlator.
// Assumes samples are two's-complement I/Q pairs of SAMP_W bits.
package dwc_pkg;
    localparam int SAMP_W  = 16;
    localparam int SCORE_W = 2 * SAMP_W + 1;

    typedef logic signed [SAMP_W-1:0]  comp_t;
    typedef logic signed [SCORE_W-1:0] score_t;

    typedef struct packed {
        comp_t re;
        comp_t im;
    } cplx_t;

    typedef enum logic {
        WIN_TRACK = 1'b0,
        WIN_ROVE  = 1'b1
    } win_id_e;
endpackage

// File: rtl/dwc_hist.sv
// Right-sample history: tap k holds the sample pushed k pushes ago.
// Assumes DEPTH covers the largest shift plus one (shift 0 is tap 0).
module dwc_hist
    import dwc_pkg::*;
#(
    parameter int DEPTH = 129
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  cplx_t                din,
    output cplx_t [DEPTH-1:0]    taps
);
    // Shift a new right sample in on every valid pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (push) begin
            taps <= {taps[DEPTH-2:0], din};
        end
    end
endmodule

// File: rtl/dwc_place.sv
// Window placement: turns a centre disparity into the lowest shift of a
// WIN-wide window, kept inside [0, eff_max]. Assumes eff_max >= WIN-1.
module dwc_place #(
    parameter int DW  = 8,
    parameter int WIN = 9
) (
    input  logic [DW-1:0] centre,
    input  logic [DW-1:0] eff_max,
    output logic [DW-1:0] lo
);
    localparam int          HALF   = (WIN - 1) / 2;
    localparam logic [DW:0] HALF_V = (DW+1)'(HALF);
    localparam logic [DW:0] SPAN_V = (DW+1)'(WIN - 1);

    logic [DW:0] c_ext;
    logic [DW:0] m_ext;

    // Clamp the window against the low and high disparity limits.
    always_comb begin
        c_ext = {1'b0, centre};
        m_ext = {1'b0, eff_max};
        if (c_ext < HALF_V) begin
            lo = '0;
        end else if (c_ext + HALF_V > m_ext) begin
            lo = DW'(m_ext - SPAN_V);
        end else begin
            lo = DW'(c_ext - HALF_V);
        end
    end
endmodule

// File: rtl/dwc_rove.sv
// Roving centre sequencer: FIRST, then steps of STEP up to eff_max,
// then one frame at 0, then back to FIRST. Advances on each strobe.
module dwc_rove #(
    parameter int DW    = 8,
    parameter int FIRST = 10,
    parameter int STEP  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [DW-1:0] eff_max,
    output logic [DW-1:0] centre
);
    localparam logic [DW-1:0] FIRST_V = DW'(FIRST);
    localparam logic [DW:0]   STEP_V  = (DW+1)'(STEP);

    logic [DW:0] nxt_sum;
    logic [DW:0] m_ext;

    // Candidate next centre before saturation.
    always_comb begin
        nxt_sum = {1'b0, centre} + STEP_V;
        m_ext   = {1'b0, eff_max};
    end

    // Step the schedule once per frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            centre <= FIRST_V;
        end else if (adv) begin
            if (centre == '0) begin
                centre <= FIRST_V;
            end else if ({1'b0, centre} >= m_ext) begin
                centre <= '0;
            end else if (nxt_sum >= m_ext) begin
                centre <= eff_max;
            end else begin
                centre <= DW'(nxt_sum);
            end
        end
    end
endmodule

// File: rtl/dwc_window.sv
// One correlation window: WIN lanes, lane k reading the history tap at
// shift lo+k and forming Re(L * conj(R)). Lanes whose right column lies
// before the line start are flagged and zeroed. Results are registered.
module dwc_window
    import dwc_pkg::*;
#(
    parameter int DEPTH = 129,
    parameter int DW    = 8,
    parameter int CW    = 12,
    parameter int WIN   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [DW-1:0]            lo,
    input  logic [CW-1:0]            col,
    input  cplx_t                    left,
    input  cplx_t [DEPTH-1:0]        taps,
    output logic [DW-1:0]            lo_q,
    output logic [WIN-1:0]           inv_q,
    output logic [WIN*SCORE_W-1:0]   score_q
);
    localparam int XW = ((CW > DW) ? CW : DW) + 1;

    // Hold the window base alongside its scores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (en) begin
            lo_q <= lo;
        end
    end

    for (genvar k = 0; k < WIN; k++) begin : g_lane
        logic [DW-1:0] d;
        cplx_t         rs;
        logic          miss;
        score_t        prod;

        // Select the shifted right sample and form the real product.
        always_comb begin
            d    = lo + DW'(k);
            rs   = taps[d];
            miss = XW'(d) > XW'(col);
            prod = score_t'(left.re) * score_t'(rs.re)
                 + score_t'(left.im) * score_t'(rs.im);
        end

        // Register this lane's score and flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                inv_q[k]                      <= 1'b0;
                score_q[k*SCORE_W +: SCORE_W] <= '0;
            end else if (en) begin
                inv_q[k]                      <= miss;
                score_q[k*SCORE_W +: SCORE_W] <= miss ? '0 : prod;
            end
        end
    end
endmodule

// File: rtl/dual_window_corr.sv
// Dual shiftable-window correlator. Stage 1 registers the left sample,
// its column and both window centres while the right sample enters the
// history. Stage 2 places the windows and registers the scores.
// Assumes frame_start never coincides with pix_valid and MAXD >= WIN-1.
module dual_window_corr
    import dwc_pkg::*;
#(
    parameter int  MAXD  = 128,
    parameter int  WIN   = 9,
    parameter int  FIRST = 10,
    parameter int  COL_W = 12,
    localparam int DW    = $clog2(MAXD + 1),
    localparam int SCW   = 2 * SAMP_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 pix_valid,
    input  logic                 line_start,
    input  logic [DW-1:0]        max_disp,
    input  logic [DW-1:0]        trk_center,
    input  logic signed [15:0]   l_re,
    input  logic signed [15:0]   l_im,
    input  logic signed [15:0]   r_re,
    input  logic signed [15:0]   r_im,
    output logic                 out_valid,
    output logic [DW-1:0]        trk_lo,
    output logic [DW-1:0]        rov_lo,
    output logic [WIN-1:0]       trk_inv,
    output logic [WIN-1:0]       rov_inv,
    output logic [WIN*SCW-1:0]   trk_score,
    output logic [WIN*SCW-1:0]   rov_score
);
    localparam int            DEPTH   = MAXD + 1;
    localparam logic [DW-1:0] MAXD_V  = DW'(MAXD);
    localparam logic [DW-1:0] MINM_V  = DW'(WIN - 1);
    localparam logic [COL_W-1:0] COL_TOP = '1;

    logic [DW-1:0]      eff_max;
    logic [DW-1:0]      rov_c;
    logic [COL_W-1:0]   col_cnt;
    logic [COL_W-1:0]   cur_col;
    cplx_t [DEPTH-1:0]  taps;

    logic               s1_valid;
    logic [COL_W-1:0]   s1_col;
    cplx_t              s1_left;
    logic [DW-1:0]      s1_ctr [2];
    logic [DW-1:0]      lo_w   [2];
    logic [DW-1:0]      lo_o   [2];
    logic [WIN-1:0]     inv_o  [2];
    logic [WIN*SCW-1:0] sc_o   [2];

    // Effective maximum: programmed value held between WIN-1 and MAXD.
    always_comb begin
        if (max_disp > MAXD_V) begin
            eff_max = MAXD_V;
        end else if (max_disp < MINM_V) begin
            eff_max = MINM_V;
        end else begin
            eff_max = max_disp;
        end
    end

    // Column of the pixel presented this cycle.
    always_comb begin
        cur_col = line_start ? '0 : col_cnt;
    end

    // Column counter, saturating at its top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_cnt <= '0;
        end else if (pix_valid) begin
            col_cnt <= (cur_col == COL_TOP) ? cur_col : cur_col + 1'b1;
        end
    end

    // Stage 1: capture the pixel context used by both windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_col    <= '0;
            s1_left   <= '0;
            s1_ctr[0] <= '0;
            s1_ctr[1] <= '0;
        end else begin
            s1_valid <= pix_valid;
            if (pix_valid) begin
                s1_col    <= cur_col;
                s1_left   <= '{re: l_re, im: l_im};
                s1_ctr[0] <= trk_center;
                s1_ctr[1] <= rov_c;
            end
        end
    end

    // Output valid follows stage 1 by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_valid;
        end
    end

    dwc_hist #(.DEPTH(DEPTH)) u_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .push (pix_valid),
        .din  ('{re: r_re, im: r_im}),
        .taps (taps)
    );

    dwc_rove #(.DW(DW), .FIRST(FIRST), .STEP(WIN)) u_rove (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (frame_start),
        .eff_max(eff_max),
        .centre (rov_c)
    );

    for (genvar w = 0; w < 2; w++) begin : g_win
        dwc_place #(.DW(DW), .WIN(WIN)) u_place (
            .centre (s1_ctr[w]),
            .eff_max(eff_max),
            .lo     (lo_w[w])
        );

        dwc_window #(.DEPTH(DEPTH), .DW(DW), .CW(COL_W), .WIN(WIN)) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (s1_valid),
            .lo     (lo_w[w]),
            .col    (s1_col),
            .left   (s1_left),
            .taps   (taps),
            .lo_q   (lo_o[w]),
            .inv_q  (inv_o[w]),
            .score_q(sc_o[w])
        );
    end

    // Route the window results to the named output ports.
    always_comb begin
        trk_lo    = lo_o[WIN_TRACK];
        rov_lo    = lo_o[WIN_ROVE];
        trk_inv   = inv_o[WIN_TRACK];
        rov_inv   = inv_o[WIN_ROVE];
        trk_score = sc_o[WIN_TRACK];
        rov_score = sc_o[WIN_ROVE];
    end
endmodule

// File: rtl/dual_window_corr_chk.sv
// Temporal checks for dual_window_corr, attached by bind.
module dual_window_corr_chk #(
    parameter int MAXD  = 128,
    parameter int WIN   = 9,
    parameter int FIRST = 10,
    parameter int DW    = 8,
    parameter int SCW   = 33
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic               frame_start,
    input logic               out_valid,
    input logic [DW-1:0]      trk_lo,
    input logic [DW-1:0]      rov_lo,
    input logic [WIN-1:0]     trk_inv,
    input logic [WIN-1:0]     rov_inv,
    input logic [WIN*SCW-1:0] trk_score,
    input logic [WIN*SCW-1:0] rov_score,
    input logic [DW-1:0]      rov_c
);
    localparam logic [DW:0] SPAN_V = (DW+1)'(WIN - 1);
    localparam logic [DW:0] MAXD_V = (DW+1)'(MAXD);

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid, 2));

    p_lo_bound_trk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, trk_lo} + SPAN_V) <= MAXD_V);

    p_lo_bound_rov_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, rov_lo} + SPAN_V) <= MAXD_V);

    p_inv_shape_trk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((trk_inv << 1) & ~trk_inv) == '0);

    p_inv_shape_rov_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((rov_inv << 1) & ~rov_inv) == '0);

    for (genvar k = 0; k < WIN; k++) begin : g_lane_chk
        p_inv_zero_trk_r7: assert property (@(posedge clk) disable iff (!rst_n)
            trk_inv[k] |-> trk_score[k*SCW +: SCW] == '0);
        p_inv_zero_rov_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rov_inv[k] |-> rov_score[k*SCW +: SCW] == '0);
    end

    p_rov_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && rov_c == '0) |=> rov_c == DW'(FIRST));

    p_rov_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(rov_c));

    p_rov_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rov_c} <= MAXD_V);
endmodule

bind dual_window_corr dual_window_corr_chk #(
    .MAXD (MAXD),
    .WIN  (WIN),
    .FIRST(FIRST),
    .DW   (DW),
    .SCW  (SCW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .frame_start(frame_start),
    .out_valid  (out_valid),
    .trk_lo     (trk_lo),
    .rov_lo     (rov_lo),
    .trk_inv    (trk_inv),
    .rov_inv    (rov_inv),
    .trk_score  (trk_score),
    .rov_score  (rov_score),
    .rov_c      (rov_c)
);

// File: tb/sim_dual_window_corr.sv
module sim_dual_window_corr;
    localparam int MAXD  = 40;
    localparam int WIN   = 9;
    localparam int FIRST = 10;
    localparam int COL_W = 8;
    localparam int DW    = $clog2(MAXD + 1);
    localparam int SCW   = 33;
    localparam int HALF  = (WIN - 1) / 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic frame_start = 1'b0, pix_valid = 1'b0, line_start = 1'b0;
    logic [DW-1:0] max_disp = DW'(30), trk_center = '0;
    logic signed [15:0] l_re = '0, l_im = '0, r_re = '0, r_im = '0;
    logic out_valid;
    logic [DW-1:0] trk_lo, rov_lo;
    logic [WIN-1:0] trk_inv, rov_inv;
    logic [WIN*SCW-1:0] trk_score, rov_score;

    dual_window_corr #(.MAXD(MAXD), .WIN(WIN), .FIRST(FIRST), .COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
        .line_start(line_start), .max_disp(max_disp), .trk_center(trk_center),
        .l_re(l_re), .l_im(l_im), .r_re(r_re), .r_im(r_im),
        .out_valid(out_valid), .trk_lo(trk_lo), .rov_lo(rov_lo),
        .trk_inv(trk_inv), .rov_inv(rov_inv),
        .trk_score(trk_score), .rov_score(rov_score));

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 0;

    int bh_re [256];
    int bh_im [256];
    int bcol = 0;
    int brov = FIRST;

    bit p_val = 0;
    int p_tlo = 0, p_rlo = 0;
    logic [WIN-1:0] p_tinv = '0, p_rinv = '0;
    logic [WIN*SCW-1:0] p_tsc = '0, p_rsc = '0;

    function automatic int eff_m(int md);
        if (md > MAXD) return MAXD;
        if (md < WIN - 1) return WIN - 1;
        return md;
    endfunction

    function automatic int place(int c, int m);
        if (c < HALF) return 0;
        if (c + HALF > m) return m - (WIN - 1);
        return c - HALF;
    endfunction

    function automatic int rnext(int r, int m);
        if (r == 0) return FIRST;
        if (r >= m) return 0;
        if (r + WIN >= m) return m;
        return r + WIN;
    endfunction

    task automatic calc(input int x, input int lo, input int lr, input int li,
                        output logic [WIN-1:0] inv, output logic [WIN*SCW-1:0] sc);
        inv = '0;
        sc  = '0;
        for (int k = 0; k < WIN; k++) begin
            int d;
            longint s;
            d = lo + k;
            if (d > x) begin
                inv[k] = 1'b1;
            end else begin
                s = longint'(lr) * longint'(bh_re[x-d]) + longint'(li) * longint'(bh_im[x-d]);
                sc[k*SCW +: SCW] = s[SCW-1:0];
            end
        end
    endtask

    // Reference model and comparison, 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            if (rst_n) begin
                n_chk++;
                if (out_valid !== p_val ||
                    (p_val && (trk_lo !== DW'(p_tlo) || rov_lo !== DW'(p_rlo) ||
                               trk_inv !== p_tinv || rov_inv !== p_rinv ||
                               trk_score !== p_tsc || rov_score !== p_rsc))) begin
                    n_fail++;
                    $display("FAIL %s: got v=%0b tlo=%0d rlo=%0d tinv=%b rinv=%b tsc=%h rsc=%h | exp v=%0b tlo=%0d rlo=%0d tinv=%b rinv=%b tsc=%h rsc=%h",
                             cur_req, out_valid, trk_lo, rov_lo, trk_inv, rov_inv, trk_score, rov_score,
                             p_val, p_tlo, p_rlo, p_tinv, p_rinv, p_tsc, p_rsc);
                end
            end
            if (!rst_n) begin
                brov  = FIRST;
                bcol  = 0;
                p_val = 0;
            end else begin
                if (pix_valid) begin
                    int x, m;
                    x = line_start ? 0 : bcol;
                    bcol = (x == 255) ? 255 : x + 1;
                    bh_re[x] = int'(r_re);
                    bh_im[x] = int'(r_im);
                    m = eff_m(int'(max_disp));
                    p_tlo = place(int'(trk_center), m);
                    p_rlo = place(brov, m);
                    calc(x, p_tlo, int'(l_re), int'(l_im), p_tinv, p_tsc);
                    calc(x, p_rlo, int'(l_re), int'(l_im), p_rinv, p_rsc);
                    p_val = 1;
                end else begin
                    p_val = 0;
                end
                if (frame_start) brov = rnext(brov, eff_m(int'(max_disp)));
            end
        end
    end

    function automatic logic signed [15:0] dv(int s);
        return 16'((s * 7919 + 13) % 65536 - 32768);
    endfunction

    task automatic px(input int lr, input int li, input int rr, input int ri,
                      input int tc, input bit ls);
        @(negedge clk);
        pix_valid   = 1'b1;
        frame_start = 1'b0;
        line_start  = ls;
        l_re = 16'(lr); l_im = 16'(li); r_re = 16'(rr); r_im = 16'(ri);
        trk_center = DW'(tc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 1'b0; frame_start = 1'b0; line_start = 1'b0;
        end
    endtask

    task automatic strobe();
        @(negedge clk);
        pix_valid = 1'b0; line_start = 1'b0; frame_start = 1'b1;
    endtask

    // R1: reset state on the ports.
    task automatic t_reset();
        cur_req = "R1 reset";
        rst_n = 1'b0;
        idle(4);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out_valid got %0b exp 0 in reset", out_valid);
        end
        rst_n = 1'b1;
        idle(2);
    endtask

    // R1/R3/R4/R11: unclamped tracking centre, varied data, first pixel shows rov centre 10.
    task automatic t_basic();
        cur_req = "R1/R3/R4/R11 basic line";
        max_disp = DW'(30);
        for (int i = 0; i < 24; i++)
            px(dv(i), dv(i + 101), dv(i + 202), dv(i + 303), 12 + (i % 5), i == 0);
        idle(3);
    endtask

    // R5/R7: low clamp and lanes before the line start.
    task automatic t_low();
        cur_req = "R5/R7 low clamp";
        for (int i = 0; i < 14; i++)
            px(dv(3 * i + 7), dv(5 * i), dv(i + 77), dv(9 * i + 1), i % 4, i == 0);
        idle(3);
    endtask

    // R6: high clamp against M = 30 with centres up to 33.
    task automatic t_high();
        cur_req = "R6 high clamp";
        max_disp = DW'(30);
        for (int i = 0; i < 36; i++)
            px(dv(i + 900), dv(i + 950), dv(2 * i + 31), dv(i + 1), 24 + (i % 10), i == 0);
        idle(3);
    endtask

    // R8: line restart mid-stream.
    task automatic t_line();
        cur_req = "R8 line restart";
        for (int i = 0; i < 15; i++) px(dv(i + 40), dv(i + 41), dv(i + 42), dv(i + 43), 6, i == 0);
        for (int i = 0; i < 12; i++) px(dv(i + 60), dv(i + 61), dv(i + 62), dv(i + 63), 6, i == 0);
        idle(3);
    endtask

    // R2: gaps between pixels keep out_valid low.
    task automatic t_gap();
        cur_req = "R2 gaps";
        for (int i = 0; i < 10; i++) begin
            px(dv(i + 500), dv(i + 501), dv(i + 502), dv(i + 503), 8, i == 0);
            idle(1 + (i % 3));
        end
        idle(2);
    endtask

    // R3: extreme sample values reach the 33-bit range.
    task automatic t_extreme();
        cur_req = "R3 extreme values";
        for (int i = 0; i < 14; i++)
            px(-32768, -32768, -32768, -32768, 4, i == 0);
        for (int i = 0; i < 14; i++)
            px(32767, 32767, -32768, -32768, 4, i == 0);
        idle(3);
    endtask

    // R9: roving schedule across frames for M = 30 and then M = 20.
    task automatic t_rove();
        cur_req = "R9 roving schedule";
        max_disp = DW'(30);
        for (int f = 0; f < 12; f++) begin
            strobe();
            for (int i = 0; i < 36; i++) px(dv(f * 40 + i), dv(i), dv(f + i), dv(i + 3), 15, i == 0);
            idle(2);
        end
        max_disp = DW'(20);
        for (int f = 0; f < 6; f++) begin
            strobe();
            px(dv(f), dv(f + 1), dv(f + 2), dv(f + 3), 10, 1'b1);
            idle(2);
        end
    endtask

    // R10: max_disp above MAXD acts as MAXD.
    task automatic t_cap();
        cur_req = "R10 max cap";
        max_disp = DW'(63);
        for (int i = 0; i < 45; i++)
            px(dv(i + 7000), dv(i + 7100), dv(i + 7200), dv(i + 7300), 30 + (i % 20), i == 0);
        idle(2);
        for (int f = 0; f < 7; f++) begin
            strobe();
            px(dv(f + 17), dv(f + 18), dv(f + 19), dv(f + 20), 40, 1'b1);
            idle(2);
        end
        max_disp = DW'(30);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (R2 flow)");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_low();
        t_high();
        t_line();
        t_gap();
        t_extreme();
        t_rove();
        t_cap();
        idle(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule